// File: doc/BRIEF.md
# Address-Dwell Coprocessor with Pulse-Coded Replies

This block sits on a cartridge and talks to the host CPU without using the data bus. It sees only eleven upper address lines and the bus clock, and it answers only by pulsing an active-low interrupt line. The CPU requests a job by running a tight wait loop inside one of eight 16-byte address windows. The block samples the address once every four bus clocks. When it sees the same window on two samples in a row, it runs the function tied to that window once.

Through these functions the CPU can do three things. It can build a 32-bit request one bit per call. It can read result bytes, each returned as a number of interrupt pulses. It can ask for timed interrupts to split the screen. The logic that computes results lies outside the block. The block exposes the assembled request word, and a neighbouring block preloads the result word through a side load port.

Top module: `dwell_coproc`

## Requirements
- R1: While reset is asserted and after it is released, `irq_n` is high, `req_done` is 0 and `req_word` is 0.
- R2: Function n (0..7) is addressed when `bus_a` (A14..A4) equals 0x618+n, which is the window 0xE180+16·n. Any other value, including the neighbours 0x617 and 0x620, starts nothing and changes no output.
- R3: The address is sampled on every fourth bus clock, counted from reset release. A function fires only when two consecutive samples fall in the same window, and it fires only once per dwell. It becomes available again after a sample outside that window, and a different window may follow directly.
- R4: Each reply pulse holds `irq_n` low for exactly PULSE_LEN (8) clocks. After a pulse, the line stays high for at least one clock before the next pulse. Pulses of one burst start PULSE_GAP clocks apart, or later if the previous pulse is still active.
- R5: Function 0 gives one pulse that starts SPLIT_DLY clocks after the firing sample.
- R6: Function 1 clears the request word, its bit count, `req_done` and the result-byte index. It acknowledges with one pulse that starts on the clock after firing.
- R7: Function 3 shifts a 1 and function 5 shifts a 0 into the request word, MSB first, and each gives an immediate acknowledge pulse. Once 32 bits are held, further bits leave the word unchanged but are still acknowledged.
- R8: `req_done` rises on the clock after the 32nd bit, and at that point `req_word` shows the word that was sent.
- R9: With `req_done` high, function 6 returns the result byte at the current index as that many pulses (none for zero). The first byte is result bits 31..24, and the index then moves to the next lower byte and wraps after four. With `req_done` low, it gives no pulse and keeps the index.
- R10: Function 4 emits BAND_CNT (6) pulses, with the first one BAND_GAP clocks after firing and BAND_GAP clocks between starts.
- R11: Function 2 emits pulses until STREAM_TOTAL (247) stream pulses have been sent since the last function 7. A call made after the total is reached emits nothing.
- R12: Function 7 resets the stream pulse count to zero and emits no pulse.
- R13: Any new function replaces the pending pulse schedule. A pulse that is already low still completes its full width.
- R14: When `res_load` is high on a clock, `res_word` is captured as the result word used by function 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_m2 | input | 1 | CPU bus clock, which clocks the whole block |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_a | input | 11 | CPU address bits A14..A4 |
| res_load | input | 1 | Load strobe for the result word |
| res_word | input | 32 | Four result bytes, most significant byte returned first |
| irq_n | output | 1 | Active-low interrupt line carrying all replies |
| req_word | output | 32 | Request word assembled from serial bits |
| req_done | output | 1 | High once 32 request bits have been received |

## Verification
The hardest case to reach is a replaced schedule in the middle of the function-2 stream. The stimulus restarts the count, starts a stream and lets a few pulses through. It then requests a screen split, which cancels the stream while a pulse may still be low. It then calls the stream again, and the bench confirms that the two stream parts together give exactly 247 pulses. Dwells of three clocks, long dwells and back-to-back windows with no idle gap move the sampling phase against the dwell edges. The behavioural model follows the exact firing cycle in each of these cases.

// File: rtl/cop_pkg.sv
package cop_pkg;

  typedef enum logic [2:0] {
    FN_SPLIT   = 3'd0,
    FN_CLEAR   = 3'd1,
    FN_STREAM  = 3'd2,
    FN_BIT1    = 3'd3,
    FN_BANDS   = 3'd4,
    FN_BIT0    = 3'd5,
    FN_READ    = 3'd6,
    FN_RESTART = 3'd7
  } fn_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // append one bit at the LSB end, oldest bit drifts toward the MSB
  function automatic logic [31:0] shift_in(input logic [31:0] w, input logic b);
    return {w[30:0], b};
  endfunction

  // bit offset of byte lane idx when lane 0 is the most significant byte
  function automatic int lane_base(input int bytes, input int idx);
    return 8 * (bytes - 1 - idx);
  endfunction

endpackage

// File: rtl/addr_sampler.sv
module addr_sampler #(
  parameter int ADDR_W   = 11,
  parameter int DIV      = 4,
  parameter int WIN_BASE = 'h618
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              sample_tick,
  output logic              cmd_fire,
  output logic [2:0]        cmd_fn
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-4:0] WIN_TAG = BASE_V[ADDR_W-1:3];

  logic [PW-1:0] presc_q;
  logic          cur_hit;
  logic [2:0]    cur_fn;
  logic          prev_hit_q;
  logic [2:0]    prev_fn_q;
  logic          held_q;
  logic [2:0]    held_fn_q;
  logic          same_as_held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else if (presc_q == PW'(DIV - 1)) presc_q <= '0;
    else presc_q <= presc_q + 1'b1;
  end

  assign sample_tick  = (presc_q == PW'(DIV - 1));
  assign cur_hit      = (addr[ADDR_W-1:3] == WIN_TAG);
  assign cur_fn       = addr[2:0];
  assign same_as_held = held_q && cur_hit && (cur_fn == held_fn_q);
  assign cmd_fire     = sample_tick && cur_hit && prev_hit_q &&
                        (prev_fn_q == cur_fn) && !same_as_held;
  assign cmd_fn       = cur_fn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_hit_q <= 1'b0;
      prev_fn_q  <= '0;
      held_q     <= 1'b0;
      held_fn_q  <= '0;
    end else if (sample_tick) begin
      prev_hit_q <= cur_hit;
      prev_fn_q  <= cur_fn;
      held_q     <= cmd_fire || same_as_held;
      if (cmd_fire) held_fn_q <= cur_fn;
    end
  end
endmodule

// File: rtl/serial_regs.sv
module serial_regs
  import cop_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  logic [2:0]        cmd_fn,
  input  logic              res_load,
  input  logic [WORD_W-1:0] res_word,
  output logic [WORD_W-1:0] req_word,
  output logic              req_done,
  output logic [7:0]        read_byte
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int BYTES = WORD_W / 8;
  localparam int IDX_W = (BYTES > 2) ? $clog2(BYTES) : 1;

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] res_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic              full;

  assign full     = (cnt_q == CNT_W'(WORD_W));
  assign req_word = word_q;
  assign req_done = full;
  assign read_byte = full ? res_q[lane_base(BYTES, int'(idx_q)) +: 8] : 8'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else if (res_load) res_q <= res_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (cmd_fire) begin
      case (cmd_fn)
        FN_CLEAR: begin
          word_q <= '0;
          cnt_q  <= '0;
          idx_q  <= '0;
        end
        FN_BIT1, FN_BIT0: begin
          if (!full) begin
            word_q <= shift_in(word_q, cmd_fn == FN_BIT1);
            cnt_q  <= cnt_q + 1'b1;
          end
        end
        FN_READ: begin
          if (full) idx_q <= idx_q + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pulse_engine.sv
module pulse_engine
  import cop_pkg::*;
#(
  parameter int PULSE_LEN    = 8,
  parameter int PULSE_GAP    = 400,
  parameter int SPLIT_DLY    = 12400,
  parameter int BAND_GAP     = 2175,
  parameter int BAND_CNT     = 6,
  parameter int STREAM_TOTAL = 247,
  localparam int WAIT_W = $clog2(max3(SPLIT_DLY, BAND_GAP, PULSE_GAP) + 1),
  localparam int NUM_W  = $clog2(max3(STREAM_TOTAL, 255, BAND_CNT) + 1),
  localparam int LOW_W  = $clog2(PULSE_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_fire,
  input  logic [2:0]       cmd_fn,
  input  logic [7:0]       read_byte,
  output logic             irq_n,
  output logic             pulse_start,
  output logic [NUM_W-1:0] stream_cnt
);
  logic [WAIT_W-1:0] wait_q;
  logic [WAIT_W-1:0] gap_q;
  logic [NUM_W-1:0]  left_q;
  logic [NUM_W-1:0]  sent_q;
  logic [LOW_W-1:0]  low_q;
  logic              stream_q;
  logic              irq_n_q;
  logic              busy;

  int new_first;
  int new_num;
  int new_gap;

  // schedule requested by the function that fires this cycle
  always_comb begin
    new_first = 1;
    new_num   = 1;
    new_gap   = PULSE_GAP;
    case (cmd_fn)
      FN_SPLIT:   new_first = SPLIT_DLY;
      FN_STREAM:  new_num = STREAM_TOTAL - int'(sent_q);
      FN_BANDS: begin
        new_first = BAND_GAP;
        new_num   = BAND_CNT;
        new_gap   = BAND_GAP;
      end
      FN_READ:    new_num = int'(read_byte);
      FN_RESTART: new_num = 0;
      default: ;
    endcase
  end

  assign busy        = (low_q != '0) || !irq_n_q;
  assign pulse_start = !cmd_fire && (left_q != '0) && (wait_q == '0) && !busy;
  assign irq_n       = irq_n_q;
  assign stream_cnt  = sent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q   <= '0;
      gap_q    <= '0;
      left_q   <= '0;
      sent_q   <= '0;
      stream_q <= 1'b0;
    end else if (cmd_fire) begin
      wait_q   <= WAIT_W'(new_first - 1);
      gap_q    <= WAIT_W'(new_gap);
      left_q   <= NUM_W'(new_num);
      stream_q <= (cmd_fn == FN_STREAM);
      if (cmd_fn == FN_RESTART) sent_q <= '0;
    end else if (left_q != '0) begin
      if (wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
      end else if (!busy) begin
        left_q <= left_q - 1'b1;
        wait_q <= gap_q - 1'b1;
        if (stream_q) sent_q <= sent_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q   <= '0;
      irq_n_q <= 1'b1;
    end else begin
      irq_n_q <= !(pulse_start || (low_q != '0));
      if (pulse_start) low_q <= LOW_W'(PULSE_LEN - 1);
      else if (low_q != '0) low_q <= low_q - 1'b1;
    end
  end
endmodule

// File: rtl/dwell_coproc.sv
module dwell_coproc #(
  parameter int ADDR_W       = 11,
  parameter int DIV          = 4,
  parameter int WIN_BASE     = 'h618,
  parameter int WORD_W       = 32,
  parameter int PULSE_LEN    = 8,
  parameter int PULSE_GAP    = 400,
  parameter int SPLIT_DLY    = 12400,
  parameter int BAND_GAP     = 2175,
  parameter int BAND_CNT     = 6,
  parameter int STREAM_TOTAL = 247
) (
  input  logic              clk_m2,
  input  logic              rst_n,
  input  logic [10:0]       bus_a,
  input  logic              res_load,
  input  logic [31:0]       res_word,
  output logic              irq_n,
  output logic [31:0]       req_word,
  output logic              req_done
);
  localparam int NUM_W = $clog2(cop_pkg::max3(STREAM_TOTAL, 255, BAND_CNT) + 1);

  logic             sample_tick;
  logic             cmd_fire;
  logic [2:0]       cmd_fn;
  logic [7:0]       read_byte;
  logic             pulse_start;
  logic [NUM_W-1:0] stream_cnt;

  addr_sampler #(.ADDR_W(ADDR_W), .DIV(DIV), .WIN_BASE(WIN_BASE)) u_sampler (
    .clk(clk_m2), .rst_n(rst_n), .addr(bus_a),
    .sample_tick(sample_tick), .cmd_fire(cmd_fire), .cmd_fn(cmd_fn)
  );

  serial_regs #(.WORD_W(WORD_W)) u_regs (
    .clk(clk_m2), .rst_n(rst_n), .cmd_fire(cmd_fire), .cmd_fn(cmd_fn),
    .res_load(res_load), .res_word(res_word),
    .req_word(req_word), .req_done(req_done), .read_byte(read_byte)
  );

  pulse_engine #(
    .PULSE_LEN(PULSE_LEN), .PULSE_GAP(PULSE_GAP), .SPLIT_DLY(SPLIT_DLY),
    .BAND_GAP(BAND_GAP), .BAND_CNT(BAND_CNT), .STREAM_TOTAL(STREAM_TOTAL)
  ) u_engine (
    .clk(clk_m2), .rst_n(rst_n), .cmd_fire(cmd_fire), .cmd_fn(cmd_fn),
    .read_byte(read_byte), .irq_n(irq_n), .pulse_start(pulse_start),
    .stream_cnt(stream_cnt)
  );
endmodule

// File: rtl/dwell_coproc_chk.sv
module dwell_coproc_chk #(
  parameter int PULSE_LEN    = 8,
  parameter int STREAM_TOTAL = 247,
  parameter int NUM_W        = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_n,
  input logic             cmd_fire,
  input logic [2:0]       cmd_fn,
  input logic             pulse_start,
  input logic [NUM_W-1:0] stream_cnt,
  input logic [31:0]      req_word,
  input logic             req_done
);
  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (irq_n) low_run <= '0;
    else if (low_run != 16'hFFFF) low_run <= low_run + 1'b1;
  end

  // R4
  irq_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= 16'(PULSE_LEN));

  // R4
  start_drives_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_start |=> !irq_n);

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_start |-> irq_n);

  // R6
  clear_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_fn == 3'd1) |=> (!req_done && req_word == 32'd0));

  // R8
  done_from_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_done) |-> $past(cmd_fire));

  // R11
  stream_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(stream_cnt) <= STREAM_TOTAL);

  // R12
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_fn == 3'd7) |=> (stream_cnt == '0));
endmodule

bind dwell_coproc dwell_coproc_chk #(
  .PULSE_LEN(PULSE_LEN), .STREAM_TOTAL(STREAM_TOTAL), .NUM_W(NUM_W)
) u_chk (
  .clk(clk_m2), .rst_n(rst_n), .irq_n(irq_n), .cmd_fire(cmd_fire),
  .cmd_fn(cmd_fn), .pulse_start(pulse_start), .stream_cnt(stream_cnt),
  .req_word(req_word), .req_done(req_done)
);

// File: tb/test_dwell_coproc.sv
module test_dwell_coproc;
  localparam int DIV   = 4;
  localparam int PGAP  = 40;
  localparam int SPLIT = 300;
  localparam int BGAP  = 120;
  localparam int BCNT  = 6;
  localparam int STOT  = 247;
  localparam int PLEN  = 8;
  localparam logic [10:0] IDLE = 11'h000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] addr;
  logic        res_load;
  logic [31:0] res_word;
  wire         irq_n;
  wire  [31:0] req_word;
  wire         req_done;

  always #5 clk = ~clk;

  dwell_coproc #(
    .PULSE_LEN(PLEN), .PULSE_GAP(PGAP), .SPLIT_DLY(SPLIT),
    .BAND_GAP(BGAP), .BAND_CNT(BCNT), .STREAM_TOTAL(STOT)
  ) i_dwell_coproc (
    .clk_m2(clk), .rst_n(rst_n), .bus_a(addr), .res_load(res_load),
    .res_word(res_word), .irq_n(irq_n), .req_word(req_word), .req_done(req_done)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string tag = "R1";
  int    falls = 0;
  logic  last_irq = 1'b1;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every active edge
  int          m_e = 0;
  bit          m_prev_hit = 0, m_held = 0, m_stream = 0, m_irq = 1;
  int          m_prev_fn = 0, m_held_fn = 0;
  int          m_left = 0, m_due = 0, m_gap = PGAP, m_last = -100, m_sent = 0;
  logic [31:0] m_word = 0, m_res = 0;
  int          m_bits = 0, m_idx = 0;

  always @(posedge clk) begin : model
    bit tick, hit, same, fire;
    int fn, first, num, gap;
    if (rst_n) begin
      tick = (m_e % DIV) == DIV - 1;
      hit  = (addr[10:3] == 8'hC3);
      fn   = int'(addr[2:0]);
      fire = 0;
      if (tick) begin
        same = m_held && hit && (fn == m_held_fn);
        fire = hit && m_prev_hit && (m_prev_fn == fn) && !same;
        m_held = fire || same;
        if (fire) m_held_fn = fn;
        m_prev_hit = hit;
        m_prev_fn  = fn;
      end
      if (fire) begin
        first = 1; num = 1; gap = PGAP;
        case (fn)
          0: first = SPLIT;
          1: begin m_word = 0; m_bits = 0; m_idx = 0; end
          2: num = STOT - m_sent;
          3, 5: if (m_bits < 32) begin
                  m_word = {m_word[30:0], (fn == 3) ? 1'b1 : 1'b0};
                  m_bits++;
                end
          4: begin first = BGAP; num = BCNT; gap = BGAP; end
          6: if (m_bits == 32) begin
               num = int'((m_res >> (8 * (3 - m_idx))) & 32'hFF);
               m_idx = (m_idx + 1) % 4;
             end else num = 0;
          default: begin num = 0; m_sent = 0; end
        endcase
        m_left = num; m_due = m_e + first; m_gap = gap; m_stream = (fn == 2);
      end else if (m_left > 0 && m_e >= m_due && m_e > m_last + 8) begin
        m_last = m_e; m_left--; m_due = m_e + m_gap;
        if (m_stream) m_sent++;
      end
      if (res_load) m_res = res_word;
      m_irq = !(m_e <= m_last + PLEN - 1);
      m_e++;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(irq_n === m_irq, tag, "irq_n vs model", longint'(irq_n), longint'(m_irq));
      check(req_word === m_word, tag, "req_word vs model", longint'(req_word), longint'(m_word));
      check(req_done === (m_bits == 32), tag, "req_done vs model",
            longint'(req_done), longint'(m_bits == 32));
      if (last_irq && !irq_n) falls++;
      last_irq = irq_n;
    end
  end

  task automatic idle(input int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  task automatic dwell(input int fn, input int cyc);
    @(negedge clk);
    addr = 11'h618 + 11'(fn);
    repeat (cyc) @(negedge clk);
    addr = IDLE;
  endtask

  task automatic expect_falls(input int exp, input string rq);
    #1;
    check(falls == exp, rq, "pulse count", falls, exp);
    falls = 0;
  endtask

  task automatic send_bit(input bit b);
    dwell(b ? 3 : 5, 12);
    idle(16);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic [31:0] msg;
    int part_a, part_b, part_c;
    rst_n = 1'b0; addr = IDLE; res_load = 1'b0; res_word = '0;
    idle(3);
    // R1 reset state
    check(irq_n === 1'b1, "R1", "irq_n in reset", longint'(irq_n), 1);
    check(req_done === 1'b0, "R1", "req_done in reset", longint'(req_done), 0);
    check(req_word === 32'd0, "R1", "req_word in reset", longint'(req_word), 0);
    rst_n = 1'b1;
    idle(2);

    // R14 preload results 3,0,5,1
    tag = "R14";
    res_word = 32'h0300_0501; res_load = 1'b1; idle(1); res_load = 1'b0; res_word = '0;

    // R2 neighbouring addresses are ignored
    tag = "R2";
    @(negedge clk); addr = 11'h617; idle(40);
    addr = 11'h620; idle(40); addr = IDLE; idle(30);
    expect_falls(0, "R2");
    check(req_word === 32'd0, "R2", "word after near miss", longint'(req_word), 0);

    // R3 three-clock dwell holds at most one sample
    tag = "R3";
    dwell(1, 3); idle(30);
    expect_falls(0, "R3");

    // R9 read before a full request gives nothing
    tag = "R9";
    dwell(6, 40); idle(30);
    expect_falls(0, "R9");

    // R6 clear with ack
    tag = "R6";
    dwell(1, 40); idle(30);
    expect_falls(1, "R6");

    // R7 R8 shift a full word MSB first
    tag = "R7";
    msg = 32'hA5C3_0F96;
    for (int i = 31; i >= 0; i--) send_bit(msg[i]);
    idle(10);
    expect_falls(32, "R7");
    check(req_word === msg, "R8", "assembled word", longint'(req_word), longint'(msg));
    check(req_done === 1'b1, "R8", "done flag", longint'(req_done), 1);
    send_bit(1'b0); idle(10);
    expect_falls(1, "R7");
    check(req_word === msg, "R7", "word after extra bit", longint'(req_word), longint'(msg));

    // R9 R14 four result bytes
    tag = "R9";
    dwell(6, 20); idle(6 * PGAP); expect_falls(3, "R9");
    dwell(6, 20); idle(6 * PGAP); expect_falls(0, "R9");
    dwell(6, 20); idle(6 * PGAP); expect_falls(5, "R14");
    dwell(6, 20); idle(6 * PGAP); expect_falls(1, "R9");

    // R5 long dwell, single delayed split
    tag = "R5";
    dwell(0, 100); idle(SPLIT);
    expect_falls(1, "R5");

    // R10 band sequence
    tag = "R10";
    dwell(4, 20); idle(BGAP * (BCNT + 1) + 40);
    expect_falls(BCNT, "R10");

    // R12 R11 full stream then a further call
    tag = "R12";
    dwell(7, 20); idle(40);
    expect_falls(0, "R12");
    tag = "R11";
    dwell(2, 20); idle(STOT * PGAP + 200);
    expect_falls(STOT, "R11");
    dwell(2, 20); idle(200);
    expect_falls(0, "R11");

    // R13 stream cut by a split, then resumed
    tag = "R13";
    dwell(7, 20); idle(20); falls = 0;
    dwell(2, 20); idle(5 * PGAP);
    #1 part_a = falls; falls = 0;
    dwell(0, 12); idle(SPLIT + 60);
    #1 part_b = falls; falls = 0;
    dwell(2, 20); idle(STOT * PGAP + 200);
    #1 part_c = falls; falls = 0;
    check(part_a + part_b + part_c == STOT + 1, "R13", "stream plus split pulses",
          part_a + part_b + part_c, STOT + 1);

    // R3 rearm across windows without idle
    tag = "R3";
    dwell(1, 20); idle(20);
    @(negedge clk); addr = 11'h618 + 11'd3; idle(40);
    addr = 11'h618 + 11'd5; idle(40); addr = IDLE; idle(30);
    expect_falls(3, "R3");
    check(req_word === 32'd2, "R3", "two bits from two windows", longint'(req_word), 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule